// File: doc/BRIEF.md
# Program Memory Word Access Unit

This unit lets software reach a program memory that is 16 bits wide using only byte-sized register accesses. It holds a bank of 24-bit word addresses. A small select register chooses one of them, and that chosen address shows through three byte registers. A pair of byte registers holds the 16-bit data word. Software sets up an address and a data word, then issues a read, write or erase command. The unit runs a request/acknowledge exchange with the memory port for that command.

A write-enable bit gates write and erase commands. A single busy flag shows when the memory port is in use, either by a command in flight or by an instruction fetch that is signalled from outside. A command that arrives while the port is busy is dropped. The sequencer has four states. IDLE waits for an accepted command. RD_WAIT, WR_WAIT and ER_WAIT each hold the memory request until the acknowledge arrives, and then return to IDLE. RD_WAIT also captures the returned word on that return.

Top module: `pmem_word_unit`

## Requirements
- R1: After reset, the select register, every pointer byte and both data bytes read 0, busy is 0 and mem_req is 0.
- R2: Register index 1 reads bits 23:16 of the selected pointer, index 2 reads bits 15:8 and index 3 reads bits 7:0. Register reads are combinational.
- R3: A write to index 1, 2 or 3 changes only that byte of the selected pointer. All other bytes and all other pointers keep their values.
- R4: A write to index 0 stores the low log2(N_PTR) bits of the byte as the select value, and index 0 reads that value zero-extended. The very next register read already uses the new pointer.
- R5: A read command (cmd_op 01) raises mem_req with mem_addr equal to the selected pointer at the moment of issue. mem_req and mem_addr stay steady until mem_ack. On the acknowledge, mem_rdata[15:8] goes into data-high (index 4) and mem_rdata[7:0] goes into data-low (index 5).
- R6: A write command (cmd_op 10) raises mem_req with mem_we=1 and mem_wdata = {data-high, data-low} as they stood at issue.
- R7: An erase command (cmd_op 11) raises mem_req with mem_erase=1 and mem_we=0. mem_we and mem_erase are never 1 together.
- R8: While wr_enable is 0, write and erase commands start no memory request and leave memory unchanged. Read commands still run.
- R9: busy (and bit 0 of status index 6) is 1 while fetch_req is 1 or a command is in flight, and 0 otherwise. Writes to index 6 have no effect.
- R10: A command issued while busy is 1 is discarded and starts no memory request. cmd_op 00 never starts a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Register index (0 sel, 1-3 pointer bytes, 4-5 data bytes, 6 status) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 none, 01 read, 10 write, 11 erase |
| wr_enable | input | 1 | Allows write and erase when 1 |
| fetch_req | input | 1 | Instruction fetch occupying the port |
| busy | output | 1 | Port in use |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a word write |
| mem_erase | output | 1 | Request is an erase |
| mem_addr | output | 24 | Word address |
| mem_wdata | output | 16 | Write word |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 16 | Read word |

## Verification
The bench builds the unit with N_PTR=4. This makes it practical to write every byte of every pointer and to read back the whole bank after each select change, so any cross-talk between pointers or bytes shows up. With only four pointers, each one can also aim at its own memory word, so read commands are swept across all of them. The expected words are computed arithmetically from each address. Protection, fetch overlap and back-to-back commands are then checked by counting request starts at the port.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_WR_WAIT = 2'd2,
        ST_ER_WAIT = 2'd3
    } pmw_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_ERASE = 2'b11
    } pmw_op_e;

    localparam logic [2:0] IDX_SEL   = 3'd0;
    localparam logic [2:0] IDX_PTR_U = 3'd1;
    localparam logic [2:0] IDX_PTR_H = 3'd2;
    localparam logic [2:0] IDX_PTR_L = 3'd3;
    localparam logic [2:0] IDX_DAT_H = 3'd4;
    localparam logic [2:0] IDX_DAT_L = 3'd5;
    localparam logic [2:0] IDX_STAT  = 3'd6;
endpackage

// File: rtl/pmw_ptr_bank.sv
module pmw_ptr_bank #(
    parameter int N_PTR     = 8,
    parameter int PTR_BYTES = 3,
    localparam int SEL_W    = $clog2(N_PTR),
    localparam int PTR_W    = 8 * PTR_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     sel,
    input  logic [PTR_BYTES-1:0] byte_we,
    input  logic [7:0]           wbyte,
    output logic [PTR_W-1:0]     ptr_out
);
    logic [PTR_W-1:0] ptr_q [N_PTR];

    for (genvar p = 0; p < N_PTR; p++) begin : g_ptr
        for (genvar b = 0; b < PTR_BYTES; b++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ptr_q[p][b*8 +: 8] <= 8'h00;
                else if (byte_we[b] && (sel == SEL_W'(p)))
                    ptr_q[p][b*8 +: 8] <= wbyte;
            end
        end
    end

    assign ptr_out = ptr_q[sel];
endmodule

// File: rtl/pmw_seq.sv
module pmw_seq
    import pmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       wr_enable,
    input  logic       fetch_req,
    input  logic       mem_ack,
    output logic       accept,
    output logic       load_rd,
    output logic       busy,
    output logic       mem_req,
    output logic       mem_we,
    output logic       mem_erase
);
    pmw_state_e state_q, state_d;
    pmw_op_e    op;

    assign op = pmw_op_e'(cmd_op);

    always_comb begin
        accept = 1'b0;
        if (state_q == ST_IDLE && cmd_valid && !fetch_req) begin
            unique case (op)
                OP_READ:           accept = 1'b1;
                OP_WRITE, OP_ERASE: accept = wr_enable;
                default:           accept = 1'b0;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (op)
                        OP_READ:  state_d = ST_RD_WAIT;
                        OP_WRITE: state_d = ST_WR_WAIT;
                        OP_ERASE: state_d = ST_ER_WAIT;
                        default:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_RD_WAIT, ST_WR_WAIT, ST_ER_WAIT: begin
                if (mem_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_WR_WAIT);
        mem_erase = (state_q == ST_ER_WAIT);
        load_rd   = (state_q == ST_RD_WAIT) && mem_ack;
        busy      = fetch_req || (state_q != ST_IDLE);
    end
endmodule

// File: rtl/pmem_word_unit.sv
module pmem_word_unit
    import pmw_pkg::*;
#(
    parameter int N_PTR = 8,
    localparam int SEL_W = $clog2(N_PTR)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic        wr_enable,
    input  logic        fetch_req,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_erase,
    output logic [23:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [15:0] mem_rdata
);
    logic [SEL_W-1:0] sel_q;
    logic [7:0]       dat_h_q, dat_l_q;
    logic [23:0]      ptr_cur;
    logic [2:0]       byte_we;
    logic             accept, load_rd;

    assign byte_we[2] = reg_wr && (reg_addr == IDX_PTR_U);
    assign byte_we[1] = reg_wr && (reg_addr == IDX_PTR_H);
    assign byte_we[0] = reg_wr && (reg_addr == IDX_PTR_L);

    pmw_ptr_bank #(.N_PTR(N_PTR), .PTR_BYTES(3)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel_q),
        .byte_we (byte_we),
        .wbyte   (reg_wdata),
        .ptr_out (ptr_cur)
    );

    pmw_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .wr_enable (wr_enable),
        .fetch_req (fetch_req),
        .mem_ack   (mem_ack),
        .accept    (accept),
        .load_rd   (load_rd),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_erase (mem_erase)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q     <= '0;
            dat_h_q   <= 8'h00;
            dat_l_q   <= 8'h00;
            mem_addr  <= 24'h0;
            mem_wdata <= 16'h0;
        end else begin
            if (reg_wr && reg_addr == IDX_SEL)   sel_q   <= reg_wdata[SEL_W-1:0];
            if (reg_wr && reg_addr == IDX_DAT_H) dat_h_q <= reg_wdata;
            if (reg_wr && reg_addr == IDX_DAT_L) dat_l_q <= reg_wdata;
            if (load_rd) begin
                dat_h_q <= mem_rdata[15:8];
                dat_l_q <= mem_rdata[7:0];
            end
            if (accept) begin
                mem_addr  <= ptr_cur;
                mem_wdata <= {dat_h_q, dat_l_q};
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            IDX_SEL:   reg_rdata = {{(8-SEL_W){1'b0}}, sel_q};
            IDX_PTR_U: reg_rdata = ptr_cur[23:16];
            IDX_PTR_H: reg_rdata = ptr_cur[15:8];
            IDX_PTR_L: reg_rdata = ptr_cur[7:0];
            IDX_DAT_H: reg_rdata = dat_h_q;
            IDX_DAT_L: reg_rdata = dat_l_q;
            IDX_STAT:  reg_rdata = {7'b0, busy};
            default:   reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/pmw_checker.sv
module pmw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_enable,
    input logic        fetch_req,
    input logic        busy,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_erase,
    input logic        mem_ack,
    input logic [23:0] mem_addr
);
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req);

    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(mem_addr));

    a_r7_kind_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !(mem_we && mem_erase));

    a_r7_kind_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> $stable(mem_we) && $stable(mem_erase));

    a_r8_protect: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) && (mem_we || mem_erase) |-> $past(wr_enable));

    a_r9_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || fetch_req) |-> busy);

    a_r10_no_fetch_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> !$past(fetch_req));
endmodule

bind pmem_word_unit pmw_checker u_pmw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_enable (wr_enable),
    .fetch_req (fetch_req),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_erase (mem_erase),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/test_pmem_word_unit.sv
module test_pmem_word_unit;
    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic        wr_enable = 1'b1;
    logic        fetch_req = 1'b0;
    logic        busy, mem_req, mem_we, mem_erase;
    logic [23:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pmem_word_unit #(.N_PTR(NP)) i_pmem_word_unit (.*);

    // memory model
    logic [15:0] mem [64];
    int lat = 0;
    int req_starts = 0;
    logic req_prev = 1'b0;
    logic [23:0] last_addr;
    logic [15:0] last_wdata;
    logic        last_we, last_er;

    function automatic logic [15:0] init_word(int a);
        return 16'((a * 16'h0101) ^ 16'h5A3C);
    endfunction

    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            if (lat == 1) begin
                mem_ack <= 1'b1;
                mem_rdata <= mem[mem_addr[5:0]];
                if (mem_we)    mem[mem_addr[5:0]] <= mem_wdata;
                if (mem_erase) mem[mem_addr[5:0]] <= 16'hFFFF;
                lat <= 0;
            end else lat <= lat + 1;
        end else begin
            mem_ack <= 1'b0;
            lat <= 0;
        end
    end

    always @(posedge clk) begin
        req_prev <= mem_req;
        if (mem_req && !req_prev) begin
            req_starts <= req_starts + 1;
            last_addr  <= mem_addr;
            last_wdata <= mem_wdata;
            last_we    <= mem_we;
            last_er    <= mem_erase;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic issue(logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] pat(int p, int b);
        return 8'(((p * 3 + b) * 17 + 5));
    endfunction

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int s0;
        for (int i = 0; i < 64; i++) mem[i] = init_word(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 reg", {24'h0, v}, 32'h0);
        end
        chk("R1 busy", {31'h0, busy}, 0);
        chk("R1 mem_req", {31'h0, mem_req}, 0);

        // R3/R2: fill every byte of every pointer
        for (int p = 0; p < NP; p++) begin
            wr(3'd0, 8'(p));
            for (int b = 0; b < 3; b++) wr(3'(3 - b), pat(p, b));
        end
        // R4/R2: sweep select and read back whole bank
        for (int p = 0; p < NP; p++) begin
            wr(3'd0, 8'(p));
            rd(3'd0, v); chk("R4 sel readback", {24'h0, v}, p);
            for (int b = 0; b < 3; b++) begin
                rd(3'(3 - b), v);
                chk("R2 window byte", {24'h0, v}, {24'h0, pat(p, b)});
            end
        end
        // R4: upper select bits dropped
        wr(3'd0, 8'hFE);
        rd(3'd0, v); chk("R4 sel truncate", {24'h0, v}, 2);
        rd(3'd2, v); chk("R4 window after trunc", {24'h0, v}, {24'h0, pat(2, 1)});

        // R3: single byte rewrite of pointer 2 only
        wr(3'd2, 8'hC3);
        rd(3'd1, v); chk("R3 upper kept", {24'h0, v}, {24'h0, pat(2, 2)});
        rd(3'd2, v); chk("R3 high changed", {24'h0, v}, 32'hC3);
        rd(3'd3, v); chk("R3 low kept", {24'h0, v}, {24'h0, pat(2, 0)});
        for (int p = 0; p < NP; p++) begin
            if (p == 2) continue;
            wr(3'd0, 8'(p));
            rd(3'd2, v); chk("R3 other ptr", {24'h0, v}, {24'h0, pat(p, 1)});
        end

        // R5: point each pointer at word 8+p and read
        for (int p = 0; p < NP; p++) begin
            wr(3'd0, 8'(p));
            wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'(8 + p));
        end
        for (int p = 0; p < NP; p++) begin
            wr(3'd0, 8'(p));
            issue(2'b01);
            chk("R9 busy during read", {31'h0, busy}, 1);
            rd(3'd6, v); chk("R9 status during read", {24'h0, v}, 1);
            wait_idle();
            chk("R5 addr", {8'h0, last_addr}, 8 + p);
            rd(3'd4, v); chk("R5 data high", {24'h0, v}, {24'h0, init_word(8 + p) >> 8});
            rd(3'd5, v); chk("R5 data low", {24'h0, v}, {24'h0, init_word(8 + p) & 16'hFF});
        end

        // R6: write word via pointer 0 (address 8)
        wr(3'd0, 8'd0);
        wr(3'd4, 8'hBE); wr(3'd5, 8'hEF);
        issue(2'b10);
        wait_idle();
        chk("R6 we", {31'h0, last_we}, 1);
        chk("R6 wdata", {16'h0, last_wdata}, 32'hBEEF);
        chk("R6 memory", {16'h0, mem[8]}, 32'hBEEF);

        // R7: erase word 9 via pointer 1
        wr(3'd0, 8'd1);
        issue(2'b11);
        wait_idle();
        chk("R7 erase flag", {30'h0, last_er, last_we}, 32'h2);
        chk("R7 memory", {16'h0, mem[9]}, 32'hFFFF);

        // R8: protected write and erase
        wr_enable = 1'b0;
        s0 = req_starts;
        wr(3'd0, 8'd2);
        wr(3'd4, 8'h12); wr(3'd5, 8'h34);
        issue(2'b10);
        chk("R8 write busy", {31'h0, busy}, 0);
        issue(2'b11);
        repeat (4) @(negedge clk);
        chk("R8 no request", req_starts, s0);
        chk("R8 memory kept", {16'h0, mem[10]}, {16'h0, init_word(10)});
        issue(2'b01);
        wait_idle();
        chk("R8 read allowed", req_starts, s0 + 1);
        rd(3'd4, v); chk("R8 read data", {24'h0, v}, {24'h0, init_word(10) >> 8});
        wr_enable = 1'b1;

        // R9: fetch busy and status write ignored
        wr(3'd6, 8'hFF);
        rd(3'd6, v); chk("R9 status write ignored", {24'h0, v}, 0);
        fetch_req = 1'b1;
        #1;
        chk("R9 busy on fetch", {31'h0, busy}, 1);
        rd(3'd6, v); chk("R9 status on fetch", {24'h0, v}, 1);

        // R10: command during fetch discarded
        s0 = req_starts;
        issue(2'b01);
        fetch_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 fetch discard", req_starts, s0);

        // R10: command during command discarded
        wr(3'd0, 8'd3);
        wr(3'd4, 8'h77); wr(3'd5, 8'h66);
        issue(2'b01);
        issue(2'b10);
        wait_idle();
        repeat (4) @(negedge clk);
        chk("R10 busy discard", req_starts, s0 + 1);
        chk("R10 memory kept", {16'h0, mem[11]}, {16'h0, init_word(11)});

        // R10: op none
        issue(2'b00);
        repeat (3) @(negedge clk);
        chk("R10 op none", req_starts, s0 + 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule